// File: doc/BRIEF.md
# Address-Sliced TL-UL Request Router

This block connects one TL-UL host port to a configurable set of downstream TL-UL device ports, between 1 and 16. It divides its assigned address window into sixteen equal slots. A fixed four-bit field of the request address picks the slot, and slot `k` belongs to device `k`. The router holds no state. Every output is a combinational function of the current inputs, so it adds no latency and no storage to the path between host and devices.

The A-channel payload goes out to all devices. Only the device that owns the addressed slot sees `a_valid`. Responses come back from the lowest-numbered device that presents one. A request that targets a slot with no device behind it is not lost: the router accepts it and answers with an error response in the same cycle.

Top module: `tlul_slice_mux`

## Requirements
- R1: The slot index is address bits `[SlotLsb+3:SlotLsb]` (bits [15:12] by default, so each slot spans 4 KiB). When the host asserts `a_valid` and the index is below `NumDevices`, exactly the device with that index sees `a_valid` high, and every other device sees it low.
- R2: Every device receives the host's A-channel fields (opcode, param, size, source, address, mask, data) unchanged, whatever the selected slot.
- R3: For a slot that has a device, the host's `a_ready` equals the `a_ready` of that device.
- R4: When one or more devices assert `d_valid`, the host receives the D-channel fields of the lowest-indexed of them. The host's `d_ready` reaches only that device, and all other devices see `d_ready` low.
- R5: A request to a slot index at or above `NumDevices`, while no device asserts `d_valid`, produces a same-cycle response. That response has `d_valid`=1, `d_error`=1, `d_data`=0, `d_param`=0, `d_sink`=0, and `d_source` and `d_size` copied from the request. Its `d_opcode` is 1 (AccessAckData) for a Get (opcode 4) and 0 (AccessAck) for a Put (opcode 0 or 1). The host's `a_ready` then equals its own `d_ready`.
- R6: Device responses take precedence over the error response. While any device asserts `d_valid`, an unmapped request sees `a_ready`=0, and the device response is the one presented to the host.
- R7: Address bits outside the four-bit slot field have no effect on which device is selected.
- R8: With the host `a_valid` low, no device sees `a_valid`. With no device `d_valid` and no unmapped request, the host sees `d_valid` low.
- R9: The block has no storage. Its outputs follow an input change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_req_i | input | tl_req_t | A channel and `d_ready` from the upstream host |
| host_rsp_o | output | tl_rsp_t | D channel and `a_ready` to the upstream host |
| dev_req_o | output | NumDevices x tl_req_t | Per-device A channel and `d_ready` |
| dev_rsp_i | input | NumDevices x tl_rsp_t | Per-device D channel and `a_ready` |

## Verification
The checker checks these on every evaluation of the router:
- at most one device is targeted, and only the slot named by the address is targeted;
- the payload reaches every device unchanged;
- the host sees the targeted device's `a_ready`;
- `d_ready` is one-hot;
- every valid non-error response matches some device's response;
- error responses carry zero data and follow the host's `d_ready`.

Some things only the bench scenarios can show:
- which device wins when several responders are active, checked by a sweep of all response patterns;
- the exact echoed source, size and opcode of the error response in every unmapped slot;
- that high address bits are ignored;
- that outputs change with no clock edge.

// File: rtl/tlul_slice_pkg.sv
`timescale 1ns/1ps
package tlul_slice_pkg;

    localparam int AddrW   = 32;
    localparam int DataW   = 32;
    localparam int MaskW   = DataW / 8;
    localparam int SourceW = 8;
    localparam int SizeW   = 2;
    localparam int SlotW   = 4;
    localparam int MaxDev  = 1 << SlotW;

    localparam logic [2:0] OP_PUT_FULL    = 3'd0;
    localparam logic [2:0] OP_PUT_PARTIAL = 3'd1;
    localparam logic [2:0] OP_GET         = 3'd4;
    localparam logic [2:0] OP_ACK         = 3'd0;
    localparam logic [2:0] OP_ACK_DATA    = 3'd1;

    typedef struct packed {
        logic               a_valid;
        logic [2:0]         a_opcode;
        logic [2:0]         a_param;
        logic [SizeW-1:0]   a_size;
        logic [SourceW-1:0] a_source;
        logic [AddrW-1:0]   a_address;
        logic [MaskW-1:0]   a_mask;
        logic [DataW-1:0]   a_data;
        logic               d_ready;
    } tl_req_t;

    typedef struct packed {
        logic               d_valid;
        logic [2:0]         d_opcode;
        logic [2:0]         d_param;
        logic [SizeW-1:0]   d_size;
        logic [SourceW-1:0] d_source;
        logic               d_sink;
        logic [DataW-1:0]   d_data;
        logic               d_error;
        logic               a_ready;
    } tl_rsp_t;

endpackage

// File: rtl/slice_decode.sv
`timescale 1ns/1ps
module slice_decode
    import tlul_slice_pkg::*;
#(
    parameter int NumDevices = 6
) (
    input  logic [SlotW-1:0] field_i,
    output logic [SlotW-1:0] slot_o,
    output logic             hit_o
);

    assign slot_o = field_i;

    generate
        if (NumDevices >= MaxDev) begin : g_full
            assign hit_o = 1'b1;
        end else begin : g_partial
            assign hit_o = (field_i < SlotW'(NumDevices));
        end
    endgenerate

endmodule

// File: rtl/req_fanout.sv
`timescale 1ns/1ps
module req_fanout
    import tlul_slice_pkg::*;
#(
    parameter int NumDevices = 6
) (
    input  tl_req_t                  host_req_i,
    input  logic [SlotW-1:0]         slot_i,
    input  logic                     hit_i,
    input  logic [NumDevices-1:0]    grant_i,
    output tl_req_t [NumDevices-1:0] dev_req_o
);

    generate
        for (genvar g = 0; g < NumDevices; g++) begin : g_dev
            always_comb begin
                dev_req_o[g]         = host_req_i;
                dev_req_o[g].a_valid = host_req_i.a_valid & hit_i & (slot_i == SlotW'(g));
                dev_req_o[g].d_ready = host_req_i.d_ready & grant_i[g];
            end
        end
    endgenerate

endmodule

// File: rtl/rsp_pick.sv
`timescale 1ns/1ps
module rsp_pick
    import tlul_slice_pkg::*;
#(
    parameter int NumDevices = 6
) (
    input  tl_rsp_t [NumDevices-1:0] dev_rsp_i,
    output logic [NumDevices-1:0]    grant_o,
    output logic                     any_o,
    output tl_rsp_t                  picked_o
);

    always_comb begin
        grant_o  = '0;
        any_o    = 1'b0;
        picked_o = '0;
        for (int i = 0; i < NumDevices; i++) begin
            if (!any_o && dev_rsp_i[i].d_valid) begin
                grant_o[i] = 1'b1;
                any_o      = 1'b1;
                picked_o   = dev_rsp_i[i];
            end
        end
    end

endmodule

// File: rtl/miss_responder.sv
`timescale 1ns/1ps
module miss_responder
    import tlul_slice_pkg::*;
(
    input  logic               req_valid_i,
    input  logic               hit_i,
    input  logic               busy_i,
    input  logic               host_d_ready_i,
    input  logic [2:0]         req_opcode_i,
    input  logic [SizeW-1:0]   req_size_i,
    input  logic [SourceW-1:0] req_source_i,
    output tl_rsp_t            err_rsp_o
);

    logic answer;
    assign answer = req_valid_i & ~hit_i & ~busy_i;

    always_comb begin
        err_rsp_o = '0;
        if (answer) begin
            err_rsp_o.d_valid  = 1'b1;
            err_rsp_o.d_error  = 1'b1;
            err_rsp_o.d_opcode = (req_opcode_i == OP_GET) ? OP_ACK_DATA : OP_ACK;
            err_rsp_o.d_size   = req_size_i;
            err_rsp_o.d_source = req_source_i;
            err_rsp_o.a_ready  = host_d_ready_i;
        end
    end

endmodule

// File: rtl/tlul_slice_mux.sv
`timescale 1ns/1ps
module tlul_slice_mux
    import tlul_slice_pkg::*;
#(
    parameter int NumDevices = 6,
    parameter int SlotLsb    = 12
) (
    input  tl_req_t                  host_req_i,
    output tl_rsp_t                  host_rsp_o,
    output tl_req_t [NumDevices-1:0] dev_req_o,
    input  tl_rsp_t [NumDevices-1:0] dev_rsp_i
);

    logic [SlotW-1:0]      slot;
    logic                  hit;
    logic [NumDevices-1:0] grant;
    logic                  any_rsp;
    tl_rsp_t               picked;
    tl_rsp_t               err_rsp;
    logic                  sel_ready;

    slice_decode #(.NumDevices(NumDevices)) i_decode (
        .field_i (host_req_i.a_address[SlotLsb +: SlotW]),
        .slot_o  (slot),
        .hit_o   (hit)
    );

    rsp_pick #(.NumDevices(NumDevices)) i_pick (
        .dev_rsp_i (dev_rsp_i),
        .grant_o   (grant),
        .any_o     (any_rsp),
        .picked_o  (picked)
    );

    req_fanout #(.NumDevices(NumDevices)) i_fanout (
        .host_req_i (host_req_i),
        .slot_i     (slot),
        .hit_i      (hit),
        .grant_i    (grant),
        .dev_req_o  (dev_req_o)
    );

    miss_responder i_miss (
        .req_valid_i    (host_req_i.a_valid),
        .hit_i          (hit),
        .busy_i         (any_rsp),
        .host_d_ready_i (host_req_i.d_ready),
        .req_opcode_i   (host_req_i.a_opcode),
        .req_size_i     (host_req_i.a_size),
        .req_source_i   (host_req_i.a_source),
        .err_rsp_o      (err_rsp)
    );

    always_comb begin
        sel_ready = 1'b0;
        for (int i = 0; i < NumDevices; i++) begin
            if (slot == SlotW'(i)) sel_ready = dev_rsp_i[i].a_ready;
        end
    end

    always_comb begin
        host_rsp_o         = any_rsp ? picked : err_rsp;
        host_rsp_o.a_ready = hit ? sel_ready : err_rsp.a_ready;
    end

endmodule

// File: rtl/tlul_slice_mux_chk.sv
`timescale 1ns/1ps
module tlul_slice_mux_chk
    import tlul_slice_pkg::*;
#(
    parameter int NumDevices = 6,
    parameter int SlotLsb    = 12
) (
    input tl_req_t                  host_req_i,
    input tl_rsp_t                  host_rsp_o,
    input tl_req_t [NumDevices-1:0] dev_req_o,
    input tl_rsp_t [NumDevices-1:0] dev_rsp_i
);

    logic [NumDevices-1:0] av_vec, dr_vec, dv_vec;
    logic                  known;

    always_comb begin
        for (int i = 0; i < NumDevices; i++) begin
            av_vec[i] = dev_req_o[i].a_valid;
            dr_vec[i] = dev_req_o[i].d_ready;
            dv_vec[i] = dev_rsp_i[i].d_valid;
        end
        known = !$isunknown({host_req_i, dev_rsp_i});
    end

    always_comb begin
        if (known) begin
            assert_single_target_R1: assert ($onehot0(av_vec));
            assert_single_ready_R4: assert ($onehot0(dr_vec));
            if (!host_req_i.a_valid) begin
                assert_idle_quiet_R8: assert (av_vec == '0);
            end
            for (int i = 0; i < NumDevices; i++) begin
                if (dev_req_o[i].a_valid) begin
                    assert_slot_match_R1: assert (host_req_i.a_address[SlotLsb +: SlotW] == SlotW'(i));
                    assert_ready_path_R3: assert (host_rsp_o.a_ready == dev_rsp_i[i].a_ready);
                end
                assert_payload_copy_R2: assert (
                    {dev_req_o[i].a_opcode, dev_req_o[i].a_param, dev_req_o[i].a_size,
                     dev_req_o[i].a_source, dev_req_o[i].a_address, dev_req_o[i].a_mask,
                     dev_req_o[i].a_data} ==
                    {host_req_i.a_opcode, host_req_i.a_param, host_req_i.a_size,
                     host_req_i.a_source, host_req_i.a_address, host_req_i.a_mask,
                     host_req_i.a_data});
            end
            if (dv_vec != '0) begin
                assert_device_first_R6: assert (host_rsp_o.d_valid && (dr_vec != '0 || !host_req_i.d_ready));
            end
            if (host_rsp_o.d_valid && dv_vec == '0) begin
                assert_error_zero_data_R5: assert (host_rsp_o.d_error && host_rsp_o.d_data == '0);
                assert_error_accept_R5: assert (host_rsp_o.a_ready == host_req_i.d_ready);
            end
        end
    end

    logic fwd_seen;
    always_comb begin
        fwd_seen = 1'b0;
        for (int i = 0; i < NumDevices; i++) begin
            if (dev_rsp_i[i].d_valid &&
                {dev_rsp_i[i].d_opcode, dev_rsp_i[i].d_param, dev_rsp_i[i].d_size,
                 dev_rsp_i[i].d_source, dev_rsp_i[i].d_sink, dev_rsp_i[i].d_data,
                 dev_rsp_i[i].d_error} ==
                {host_rsp_o.d_opcode, host_rsp_o.d_param, host_rsp_o.d_size,
                 host_rsp_o.d_source, host_rsp_o.d_sink, host_rsp_o.d_data,
                 host_rsp_o.d_error})
                fwd_seen = 1'b1;
        end
        if (known && host_rsp_o.d_valid && dv_vec != '0) begin
            assert_forward_source_R4: assert (fwd_seen);
        end
    end

endmodule

bind tlul_slice_mux tlul_slice_mux_chk #(
    .NumDevices (NumDevices),
    .SlotLsb    (SlotLsb)
) i_chk (
    .host_req_i (host_req_i),
    .host_rsp_o (host_rsp_o),
    .dev_req_o  (dev_req_o),
    .dev_rsp_i  (dev_rsp_i)
);

// File: tb/test_tlul_slice_mux.sv
`timescale 1ns/1ps
module test_tlul_slice_mux;
    import tlul_slice_pkg::*;

    localparam int N = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    tl_req_t          host_req;
    tl_rsp_t          host_rsp;
    tl_req_t [N-1:0]  dev_req;
    tl_rsp_t [N-1:0]  dev_rsp;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    tlul_slice_mux #(.NumDevices(N), .SlotLsb(12)) i_tlul_slice_mux (
        .host_req_i (host_req),
        .host_rsp_o (host_rsp),
        .dev_req_o  (dev_req),
        .dev_rsp_i  (dev_rsp)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] av_vec();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = dev_req[i].a_valid;
        return v;
    endfunction

    function automatic logic [N-1:0] dr_vec();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = dev_req[i].d_ready;
        return v;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        host_req = '0;
        dev_rsp  = '0;
        repeat (3) @(negedge clk);
        #1;
        // R8: idle state while reset is held
        check(av_vec() == '0, "R8 reset no device a_valid", 64'(av_vec()), 0);
        check(host_rsp.d_valid == 1'b0, "R8 reset host d_valid", 64'(host_rsp.d_valid), 0);
        rst = 1'b0;

        // R1 R2 R3 R5 R7: sweep every slot with Get and PutFull
        for (int s = 0; s < 16; s++) begin
            for (int op = 0; op < 2; op++) begin
                for (int dr = 0; dr < 2; dr++) begin
                    logic [31:0] addr;
                    logic [2:0]  opc;
                    @(negedge clk);
                    addr = {16'(s * 16'h01F3 + op * 16'h7000), 4'(s), 12'(s * 291 + 5)};
                    opc  = (op == 0) ? OP_GET : OP_PUT_FULL;
                    for (int i = 0; i < N; i++) begin
                        dev_rsp[i]         = '0;
                        dev_rsp[i].a_ready = (i % 2 == 1);
                    end
                    host_req           = '0;
                    host_req.a_valid   = 1'b1;
                    host_req.a_opcode  = opc;
                    host_req.a_size    = 2'(s);
                    host_req.a_source  = 8'(s * 7 + op);
                    host_req.a_address = addr;
                    host_req.a_mask    = 4'(s + 1);
                    host_req.a_data    = 32'hA5A5_0000 | 32'(s);
                    host_req.d_ready   = dr[0];
                    #1;
                    for (int i = 0; i < N; i++) begin
                        check(dev_req[i].a_address == addr && dev_req[i].a_data == host_req.a_data
                              && dev_req[i].a_opcode == opc && dev_req[i].a_source == host_req.a_source
                              && dev_req[i].a_mask == host_req.a_mask && dev_req[i].a_size == host_req.a_size,
                              "R2 payload copy", 64'(dev_req[i].a_address), 64'(addr));
                    end
                    if (s < N) begin
                        check(av_vec() == N'(1 << s), "R1 R7 single target", 64'(av_vec()), 64'(1 << s));
                        check(host_rsp.a_ready == (s % 2 == 1), "R3 a_ready path",
                              64'(host_rsp.a_ready), 64'(s % 2));
                        check(host_rsp.d_valid == 1'b0, "R8 no response", 64'(host_rsp.d_valid), 0);
                    end else begin
                        check(av_vec() == '0, "R5 miss no target", 64'(av_vec()), 0);
                        check(host_rsp.d_valid && host_rsp.d_error, "R5 error response",
                              64'({host_rsp.d_valid, host_rsp.d_error}), 64'h3);
                        check(host_rsp.d_data == '0, "R5 zero data", 64'(host_rsp.d_data), 0);
                        check(host_rsp.d_source == host_req.a_source && host_rsp.d_size == host_req.a_size,
                              "R5 echo source size", 64'({host_rsp.d_source, host_rsp.d_size}),
                              64'({host_req.a_source, host_req.a_size}));
                        check(host_rsp.d_opcode == ((op == 0) ? OP_ACK_DATA : OP_ACK), "R5 opcode",
                              64'(host_rsp.d_opcode), 64'((op == 0) ? 1 : 0));
                        check(host_rsp.a_ready == dr[0], "R5 a_ready follows d_ready",
                              64'(host_rsp.a_ready), 64'(dr));
                    end
                end
            end
        end

        // R4 R8: every response pattern across the devices
        for (int m = 0; m < (1 << N); m++) begin
            int low;
            @(negedge clk);
            host_req         = '0;
            host_req.d_ready = 1'b1;
            low = -1;
            for (int i = N - 1; i >= 0; i--) begin
                dev_rsp[i]          = '0;
                dev_rsp[i].d_valid  = m[i];
                dev_rsp[i].d_data   = 32'h100 + 32'(i);
                dev_rsp[i].d_source = 8'(i + 40);
                dev_rsp[i].d_opcode = 3'(i % 2);
                if (m[i]) low = i;
            end
            #1;
            if (low < 0) begin
                check(host_rsp.d_valid == 1'b0, "R8 no responder", 64'(host_rsp.d_valid), 0);
                check(dr_vec() == '0, "R4 no d_ready", 64'(dr_vec()), 0);
            end else begin
                check(host_rsp.d_valid && host_rsp.d_data == 32'h100 + 32'(low)
                      && host_rsp.d_source == 8'(low + 40), "R4 lowest responder",
                      64'(host_rsp.d_data), 64'(32'h100 + 32'(low)));
                check(dr_vec() == N'(1 << low), "R4 d_ready to winner only",
                      64'(dr_vec()), 64'(1 << low));
            end
        end

        // R6: device response outranks an unmapped request
        for (int m = 1; m < (1 << N); m += 7) begin
            int low;
            @(negedge clk);
            host_req           = '0;
            host_req.a_valid   = 1'b1;
            host_req.a_opcode  = OP_GET;
            host_req.a_address = 32'h0000_F000;
            host_req.d_ready   = 1'b1;
            low = -1;
            for (int i = N - 1; i >= 0; i--) begin
                dev_rsp[i]         = '0;
                dev_rsp[i].d_valid = m[i];
                dev_rsp[i].d_data  = 32'h200 + 32'(i);
                dev_rsp[i].a_ready = 1'b1;
                if (m[i]) low = i;
            end
            #1;
            check(host_rsp.d_valid && !host_rsp.d_error && host_rsp.d_data == 32'h200 + 32'(low),
                  "R6 device wins", 64'(host_rsp.d_data), 64'(32'h200 + 32'(low)));
            check(host_rsp.a_ready == 1'b0, "R6 miss held", 64'(host_rsp.a_ready), 0);
        end

        // R9: response tracks an input change with no clock edge in between
        @(posedge clk);
        #0.5;
        dev_rsp           = '0;
        host_req          = '0;
        host_req.a_valid  = 1'b1;
        host_req.a_address = 32'h0000_2000;
        #0.5;
        check(av_vec() == N'(1 << 2), "R9 combinational select", 64'(av_vec()), 64'(4));
        host_req.a_address = 32'h0000_3000;
        #0.5;
        check(av_vec() == N'(1 << 3), "R9 combinational reselect", 64'(av_vec()), 64'(8));

        // R8: a_valid low reaches no device
        host_req.a_valid = 1'b0;
        #0.5;
        check(av_vec() == '0, "R8 a_valid low", 64'(av_vec()), 0);

        finish_run();
    end

endmodule